// File: doc/BRIEF.md
# Serial Slave Front-End with Pause Control

This block is the pin-facing half of a memory-style serial slave. It brings the chip-select, serial clock, data-in, pause and write-protect pins into the system clock domain through synchronizer chains, then works entirely on the synchronized copies. Incoming bits are taken on rising serial clock edges and gathered into bytes, most significant bit first. Outgoing bytes are shifted out on falling edges, most significant bit first, with a separate output-enable for a tri-state pad. Both idle clock levels work: clock resting low (mode 0) and clock resting high (mode 3).

The command layer sits behind it. It is told when a selection opens and closes, receives each finished byte, and is asked for the next outgoing byte through a request and load handshake. When the selection closes, the block states whether the number of rising clock edges seen was a whole number of bytes. The command layer uses this to reject commands that were cut off mid-byte.

The pause input freezes a transfer without deselecting the slave. Entry into and exit from the pause only take effect while the serial clock is low. After reset the block stays silent until it has seen chip-select fall. The system clock must run at least four times as fast as the serial clock.

Top module: `spi_hold_frontend`

## Requirements
- R1: Data-in is sampled on each rising serial clock edge, most significant bit first. Every eighth sample presents the assembled byte on `rx_byte` together with a one-cycle `rx_valid` pulse. This works with the clock idling low and with the clock idling high.
- R2: On the first falling serial clock edge after a byte has been completed, `miso_out` shows bit 7 of the byte most recently loaded. Each later falling edge moves on to the next lower bit.
- R3: `tx_req` pulses for one cycle, one system cycle after every `rx_valid` pulse. A `tx_load` with `tx_data` captures the byte for the next byte slot. A load that falls in the same cycle as the falling edge that starts the slot is still used.
- R4: `miso_oe` is 1 only while chip-select is low, the block is armed and no pause is active. It drops within four system cycles after chip-select rises.
- R5: If the pause pin falls while the serial clock is low, the pause begins at once. If the clock is high at that moment, the pause begins only when the clock next goes low.
- R6: If the pause pin rises while the serial clock is low, the pause ends at once. If the clock is high at that moment, the pause ends only when the clock next goes low.
- R7: While the pause is active, `miso_oe` is 0, the serial clock and data-in are ignored, and the bit position is kept. When the pause ends, the interrupted byte resumes in both directions.
- R8: If chip-select rises while the pause is active, the pause and all serial state are cleared, and the selection ends with `end_aligned` = 0.
- R9: After reset, the block reports nothing until chip-select has fallen once: no `sel_start`, `rx_valid`, `tx_req` or `miso_oe`, even if clocks arrive while chip-select is already low.
- R10: Each falling edge of chip-select gives a one-cycle `sel_start` pulse. Each rising edge gives a one-cycle `sel_end` pulse, with `end_aligned` = 1 exactly when the count of rising clock edges in that selection is a multiple of 8. `end_aligned` holds its value until the next `sel_end`.
- R11: `wp_n_sync` follows `wp_n_pin` through the synchronizer chain, within four system cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_pin | input | 1 | Chip-select pin, active low |
| sck_pin | input | 1 | Serial clock pin |
| mosi_pin | input | 1 | Serial data-in pin |
| hold_n_pin | input | 1 | Pause pin, active low |
| wp_n_pin | input | 1 | Write-protect pin, active low |
| miso_out | output | 1 | Serial data-out value |
| miso_oe | output | 1 | Output enable for the data-out pad |
| rx_byte | output | BYTE_W | Last received byte |
| rx_valid | output | 1 | One-cycle pulse: `rx_byte` is new |
| tx_req | output | 1 | One-cycle request for the next outgoing byte |
| tx_load | input | 1 | Loads `tx_data` as the next outgoing byte |
| tx_data | input | BYTE_W | Next outgoing byte |
| sel_start | output | 1 | One-cycle pulse when a selection opens |
| sel_end | output | 1 | One-cycle pulse when a selection closes |
| end_aligned | output | 1 | The closed selection held a whole number of bytes |
| hold_active | output | 1 | A pause is in effect |
| wp_n_sync | output | 1 | Synchronized write-protect level |

## Verification
Two events can land in the same system cycle: the start of a pause and a falling serial clock edge. This happens when the pause pin drops while the clock is high, so the pause waits for the clock's next low level. That same falling edge must still advance the outgoing shift register before everything freezes. The bench provokes this in the middle of a byte that is being returned. It judges the result by checking that the byte assembled from data-out, sampled before each rising edge, equals the loaded byte with no bit lost or repeated. A second collision is covered as well: chip-select rising during a pause must give an unaligned end, and the next selection must be clean.

// File: rtl/spi_hold_frontend.sv
module spi_hold_frontend #(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_pin,
  input  logic              sck_pin,
  input  logic              mosi_pin,
  input  logic              hold_n_pin,
  input  logic              wp_n_pin,
  output logic              miso_out,
  output logic              miso_oe,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              rx_valid,
  output logic              tx_req,
  input  logic              tx_load,
  input  logic [BYTE_W-1:0] tx_data,
  output logic              sel_start,
  output logic              sel_end,
  output logic              end_aligned,
  output logic              hold_active,
  output logic              wp_n_sync
);
  localparam int              CW      = $clog2(BYTE_W);
  localparam logic [CW-1:0]   LAST    = CW'(BYTE_W - 1);
  localparam int              PINS    = 5;
  // pin order {wp, hold, d, c, cs}; cs resets low so a pin held low at reset is no falling edge
  localparam logic [PINS-1:0] PIN_RST = 5'b11000;

  logic [PINS-1:0]   stg [SYNC_STAGES];
  logic              cs_s, sck_s, mosi_s, hold_n_s;
  logic              cs_q, sck_q, armed, holding;
  logic [CW-1:0]     bit_cnt;
  logic [BYTE_W-2:0] rx_sh;
  logic [BYTE_W-1:0] tx_sh, tx_next;
  logic              cs_fall, cs_rise, active, run, sck_rise, sck_fall, byte_done;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) stg[i] <= PIN_RST;
    end else begin
      stg[0] <= {wp_n_pin, hold_n_pin, mosi_pin, sck_pin, cs_n_pin};
      for (int i = 1; i < SYNC_STAGES; i++) stg[i] <= stg[i-1];
    end

  assign cs_s      = stg[SYNC_STAGES-1][0];
  assign sck_s     = stg[SYNC_STAGES-1][1];
  assign mosi_s    = stg[SYNC_STAGES-1][2];
  assign hold_n_s  = stg[SYNC_STAGES-1][3];
  assign wp_n_sync = stg[SYNC_STAGES-1][4];

  assign cs_fall   = cs_q & ~cs_s;
  assign cs_rise   = cs_s & ~cs_q;
  assign active    = armed & ~cs_s;
  assign run       = active & ~holding;
  assign sck_rise  = run & sck_s & ~sck_q;
  assign sck_fall  = run & ~sck_s & sck_q;
  assign byte_done = sck_rise & (bit_cnt == LAST);

  assign miso_oe     = run;
  assign miso_out    = tx_sh[BYTE_W-1];
  assign hold_active = holding;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_q        <= 1'b0;
      sck_q       <= 1'b0;
      armed       <= 1'b0;
      holding     <= 1'b0;
      bit_cnt     <= '0;
      rx_sh       <= '0;
      rx_byte     <= '0;
      rx_valid    <= 1'b0;
      tx_req      <= 1'b0;
      tx_sh       <= '0;
      tx_next     <= '0;
      sel_start   <= 1'b0;
      sel_end     <= 1'b0;
      end_aligned <= 1'b0;
    end else begin
      cs_q      <= cs_s;
      sck_q     <= sck_s;
      armed     <= armed | cs_fall;
      sel_start <= cs_fall;
      sel_end   <= armed & cs_rise;
      if (armed & cs_rise) end_aligned <= (bit_cnt == '0) & ~holding;
      rx_valid  <= byte_done;
      tx_req    <= rx_valid;
      if (tx_load) tx_next <= tx_data;
      if (!active) begin
        holding <= 1'b0;
        bit_cnt <= '0;
        rx_sh   <= '0;
      end else begin
        if (!holding && !hold_n_s && !sck_s)     holding <= 1'b1;
        else if (holding && hold_n_s && !sck_s)  holding <= 1'b0;
        if (sck_rise) begin
          rx_sh   <= {rx_sh[BYTE_W-3:0], mosi_s};
          bit_cnt <= byte_done ? '0 : bit_cnt + CW'(1);
        end
        if (byte_done) rx_byte <= {rx_sh, mosi_s};
        if (sck_fall)
          tx_sh <= (bit_cnt == '0) ? (tx_load ? tx_data : tx_next)
                                   : {tx_sh[BYTE_W-2:0], 1'b0};
      end
    end
endmodule

module spi_hold_frontend_chk #(
  parameter int BYTE_W = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      armed,
  input logic                      holding,
  input logic                      sck_s,
  input logic                      cs_s,
  input logic [$clog2(BYTE_W)-1:0] bit_cnt,
  input logic                      miso_oe,
  input logic                      rx_valid,
  input logic                      tx_req,
  input logic                      sel_end
);
  p_rx_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  p_req_after_rx_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> tx_req);
  p_req_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |-> $past(rx_valid));
  p_oe_desel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |-> !miso_oe);
  p_enter_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(holding) |-> $past(!sck_s && !cs_s));
  p_exit_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(holding) |-> $past(!sck_s || cs_s));
  p_hold_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    holding |-> !miso_oe);
  p_hold_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (holding && $past(holding)) |-> $stable(bit_cnt));
  p_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (!miso_oe && !rx_valid && !tx_req && !sel_end));
endmodule

bind spi_hold_frontend spi_hold_frontend_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .armed(armed), .holding(holding), .sck_s(sck_s),
  .cs_s(cs_s), .bit_cnt(bit_cnt), .miso_oe(miso_oe), .rx_valid(rx_valid),
  .tx_req(tx_req), .sel_end(sel_end));

// File: tb/spi_hold_frontend_test.sv
module spi_hold_frontend_test;
  localparam int HP = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b0, sck = 1'b0, mosi = 1'b0, hold_n = 1'b1, wp_n = 1'b1;
  logic tx_load = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic miso_out, miso_oe, rx_valid, tx_req, sel_start, sel_end, end_aligned, hold_active, wp_n_sync;
  logic [7:0] rx_byte;

  int checks = 0, bad = 0, req_n = 0, rx_cnt = 0, start_cnt = 0, end_cnt = 0;
  logic [7:0] last_rx = 8'h00;
  logic last_al = 1'b0;

  spi_hold_frontend uut (
    .clk(clk), .rst_n(rst_n), .cs_n_pin(cs_n), .sck_pin(sck), .mosi_pin(mosi),
    .hold_n_pin(hold_n), .wp_n_pin(wp_n), .miso_out(miso_out), .miso_oe(miso_oe),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .tx_req(tx_req), .tx_load(tx_load),
    .tx_data(tx_data), .sel_start(sel_start), .sel_end(sel_end),
    .end_aligned(end_aligned), .hold_active(hold_active), .wp_n_sync(wp_n_sync));

  initial forever #4 clk = ~clk;

  function automatic logic [7:0] exp_tx(input int n);
    return 8'(n * 73 + 90);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial forever begin
    @(negedge clk);
    if (rx_valid) begin last_rx = rx_byte; rx_cnt++; end
    if (sel_start) start_cnt++;
    if (sel_end) begin end_cnt++; last_al = end_aligned; end
    if (tx_req) begin tx_load = 1'b1; tx_data = exp_tx(req_n); req_n++; end
    else tx_load = 1'b0;
  end

  task automatic bit_io(input logic b, output logic q);
    sck = 1'b0; mosi = b; wait_n(HP);
    q = miso_out;
    sck = 1'b1; wait_n(HP);
  endtask

  task automatic hold_seq(input bit hi);
    logic g;
    if (!hi) begin
      sck = 1'b0; wait_n(HP);
      hold_n = 1'b0; wait_n(HP);
      chk(hold_active == 1'b1, "R5 enter with clock low", hold_active, 1);
      chk(miso_oe == 1'b0, "R7 output off in pause", miso_oe, 0);
      repeat (2) begin
        g = 1'($urandom); mosi = g; sck = 1'b1; wait_n(HP);
        mosi = ~g; sck = 1'b0; wait_n(HP);
      end
      hold_n = 1'b1; wait_n(HP);
      chk(hold_active == 1'b0, "R6 exit with clock low", hold_active, 0);
    end else begin
      hold_n = 1'b0; wait_n(2 * HP);
      chk(hold_active == 1'b0, "R5 entry waits for clock low", hold_active, 0);
      sck = 1'b0; wait_n(HP);
      chk(hold_active == 1'b1, "R5 entry at clock fall", hold_active, 1);
      mosi = ~mosi; sck = 1'b1; wait_n(HP);
      hold_n = 1'b1; wait_n(2 * HP);
      chk(hold_active == 1'b1, "R6 exit waits for clock low", hold_active, 1);
      sck = 1'b0; wait_n(HP);
      chk(hold_active == 1'b0, "R6 exit at clock fall", hold_active, 0);
    end
  endtask

  task automatic byte_io(input logic [7:0] tx, input int hold_at, input bit hi, output logic [7:0] q);
    logic qb;
    for (int j = 0; j < 8; j++) begin
      if (j == hold_at) hold_seq(hi);
      bit_io(tx[7-j], qb);
      q[7-j] = qb;
    end
  endtask

  task automatic sess_begin(input bit m3, output int base);
    int s0;
    s0 = start_cnt;
    sck = m3; mosi = 1'b0; wait_n(HP);
    cs_n = 1'b0; wait_n(2 * HP);
    base = req_n;
    chk(start_cnt == s0 + 1, "R10 start pulse", start_cnt - s0, 1);
    chk(miso_oe == 1'b1, "R4 output on while selected", miso_oe, 1);
  endtask

  task automatic sess_end(input bit m3, input bit exp_al);
    int e0;
    e0 = end_cnt;
    if (!m3) sck = 1'b0;
    wait_n(HP);
    cs_n = 1'b1; wait_n(2 * HP);
    chk(end_cnt == e0 + 1 && last_al == exp_al, "R10 end and alignment", {end_cnt - e0, 3'b0, last_al}, {1, 3'b0, exp_al});
    chk(miso_oe == 1'b0, "R4 output off when deselected", miso_oe, 0);
  endtask

  task automatic xfer(input logic [7:0] d, input int k, input int base, input int hold_at, input bit hi);
    logic [7:0] q;
    int r0;
    r0 = rx_cnt;
    byte_io(d, hold_at, hi, q);
    chk(rx_cnt == r0 + 1 && last_rx == d, "R1 byte received", last_rx, d);
    if (k > 0) chk(q == exp_tx(base + k - 1), "R2 R3 byte returned", q, exp_tx(base + k - 1));
  endtask

  initial begin
    int base;
    logic [7:0] q;
    void'($urandom(32'd4242));
    wait_n(5);
    rst_n = 1'b1;
    wait_n(4);
    chk(miso_oe == 1'b0 && rx_valid == 1'b0 && hold_active == 1'b0 && sel_end == 1'b0,
        "R4 reset state", {miso_oe, rx_valid, hold_active, sel_end}, 0);

    // R9: clocks while chip-select low since reset are ignored
    byte_io(8'hA5, -1, 1'b0, q);
    wait_n(HP);
    chk(rx_cnt == 0 && start_cnt == 0 && req_n == 0, "R9 silent before first select", rx_cnt + start_cnt + req_n, 0);
    chk(miso_oe == 1'b0, "R9 output off before first select", miso_oe, 0);
    sck = 1'b0; cs_n = 1'b1; wait_n(2 * HP);

    // R1 R2 R3 mode 0, directed
    sess_begin(1'b0, base);
    xfer(8'h9F, 0, base, -1, 1'b0);
    xfer(8'h00, 1, base, -1, 1'b0);
    xfer(8'hFF, 2, base, -1, 1'b0);
    sess_end(1'b0, 1'b1);

    // R1 R2 mode 3
    sess_begin(1'b1, base);
    xfer(8'h3C, 0, base, -1, 1'b0);
    xfer(8'hC3, 1, base, -1, 1'b0);
    sess_end(1'b1, 1'b1);

    // R10 cut-off command: 11 rising edges
    sess_begin(1'b0, base);
    xfer(8'h06, 0, base, -1, 1'b0);
    for (int j = 0; j < 3; j++) begin logic qb; bit_io(1'b1, qb); end
    sess_end(1'b0, 1'b0);

    // R5 R6 R7 pause with clock low, mid-byte of a returned byte
    sess_begin(1'b0, base);
    xfer(8'h81, 0, base, -1, 1'b0);
    xfer(8'h5A, 1, base, 4, 1'b0);
    sess_end(1'b0, 1'b1);

    // R5 R6 R7 pause requested with clock high: entry shares the fall that shifts data-out
    sess_begin(1'b0, base);
    xfer(8'h42, 0, base, -1, 1'b0);
    xfer(8'hB7, 1, base, 3, 1'b1);
    xfer(8'h11, 2, base, -1, 1'b0);
    sess_end(1'b0, 1'b1);

    // R8 chip-select rises during pause
    sess_begin(1'b0, base);
    for (int j = 0; j < 5; j++) begin logic qb; bit_io(1'b0, qb); end
    sck = 1'b0; wait_n(HP);
    hold_n = 1'b0; wait_n(HP);
    chk(hold_active == 1'b1, "R8 pause active before deselect", hold_active, 1);
    begin
      int e0;
      e0 = end_cnt;
      cs_n = 1'b1; wait_n(2 * HP);
      chk(end_cnt == e0 + 1 && last_al == 1'b0, "R8 unaligned end", last_al, 0);
    end
    chk(hold_active == 1'b0, "R8 pause cleared", hold_active, 0);
    hold_n = 1'b1; wait_n(HP);
    sess_begin(1'b0, base);
    xfer(8'hE4, 0, base, -1, 1'b0);
    xfer(8'h27, 1, base, -1, 1'b0);
    sess_end(1'b0, 1'b1);

    // R11
    wp_n = 1'b0; wait_n(4);
    chk(wp_n_sync == 1'b0, "R11 protect low", wp_n_sync, 0);
    wp_n = 1'b1; wait_n(4);
    chk(wp_n_sync == 1'b1, "R11 protect high", wp_n_sync, 1);

    // random sessions
    for (int s = 0; s < 24; s++) begin
      bit m3;
      int nb;
      m3 = 1'($urandom);
      nb = 1 + int'($urandom % 4);
      sess_begin(m3, base);
      for (int k = 0; k < nb; k++) begin
        int ha;
        ha = ($urandom % 3 == 0) ? int'($urandom % 8) : -1;
        xfer(8'($urandom), k, base, ha, 1'b0);
      end
      sess_end(m3, 1'b1);
    end

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule